// File: doc/BRIEF.md
# Display Power State Controller

This block decides the power state of a display from two activity flags, one for the horizontal sync and one for the vertical sync. Each flag is high when its sync currently shows pulses. From the pair the block picks one of four states: ON, STAND-BY, SUSPEND or OFF. It reports the state on three active-low indicators and on an optional combined indicator that is asserted in STAND-BY or SUSPEND. The flags come from a frequency detector elsewhere in the chip, in the same clock domain.

The state changes with deliberately unequal timing. Leaving ON needs a long qualification, so that a resolution change does not blank the screen. Coming back to ON needs a short pulse check. Moving between two power-saving states happens at once. All timing is measured in ticks from a prescaler on the reference clock. With a 32768 Hz clock the defaults give 32 ticks per second: 189 ticks is about 5.9 s and 12 ticks is about 0.37 s.

A synchronous reset stands for manual power-up. It places the block in an override phase. The override holds ON for as long as both syncs stay silent. The first pulses on either sync end the override for good, and normal operation starts from ON.

Top module: `dps_power_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `stby_n`, `susp_n`, `off_n` and `save_any_n` are all 1, which means no indicator is asserted.
- R2: After reset with both flags at 0, the outputs stay at the ON pattern indefinitely, even well past the entry delay.
- R3: The override ends in the first cycle where either flag is 1, and it never returns before the next reset. After it ends, every condition, including both flags at 0, is qualified as in normal operation.
- R4: Each flag pair maps to one target state. h=1,v=1 gives ON; h=0,v=1 gives STAND-BY; h=1,v=0 gives SUSPEND; h=0,v=0 gives OFF. The outputs assert, by driving low, only the matching indicator: `stby_n` for STAND-BY, `susp_n` for SUSPEND, `off_n` for OFF, and none for ON.
- R5: When the outputs show ON and a saving condition appears, the outputs change only once the condition has been present for ENTRY_TICKS ticks. That is no earlier than (ENTRY_TICKS-1)*TICK_DIV+2 clocks after the inputs change, and no later than ENTRY_TICKS*TICK_DIV+1 clocks.
- R6: If both flags return to 1 during the entry qualification, the outputs stay at ON. A later saving condition must then wait for the full entry delay again.
- R7: A change from one saving condition to another during the entry qualification does not restart it. The state entered is the condition present when the qualification completes.
- R8: When the outputs show a saving state and both flags become 1, the outputs change to ON after RECOV_TICKS ticks. That is between (RECOV_TICKS-1)*TICK_DIV+2 and RECOV_TICKS*TICK_DIV+1 clocks.
- R9: When the outputs show a saving state and the flags select a different saving state, the outputs take the new state 2 clocks after the input change.
- R10: If a saving condition appears during the recovery check, the check is abandoned and the outputs never show ON. A different saving state is entered at once, and a later return to ON needs the full recovery delay.
- R11: `save_any_n` is 0 exactly when the outputs show STAND-BY or SUSPEND.
- R12: At no time is more than one of `stby_n`, `susp_n`, `off_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset (manual power-up) |
| h_active | input | 1 | 1 when the horizontal sync shows pulses |
| v_active | input | 1 | 1 when the vertical sync shows pulses |
| stby_n | output | 1 | Low in STAND-BY |
| susp_n | output | 1 | Low in SUSPEND |
| off_n | output | 1 | Low in OFF |
| save_any_n | output | 1 | Low in STAND-BY or SUSPEND (tied high when disabled) |

## Verification
The assertions assume that both activity flags are synchronous to `clk` and hold their value across each clock edge. They also assume that reset is held for at least two edges, so every register holds its reset value before any past-value check looks back. The bench keeps to this by changing the flags only on the falling clock edge and by holding reset for several cycles. It uses small tick counts, so that every ordered pair of saving states and every recovery can be swept within the bounds given by R5 and R8.

// File: rtl/dps_pkg.sv
// Shared types for the display power state controller.
// Assumes the activity flags are already synchronous to the controller clock.
package dps_pkg;

    // Displayed power state; the encoding is internal to the block.
    typedef enum logic [1:0] {
        PM_ON   = 2'd0,
        PM_STBY = 2'd1,
        PM_SUSP = 2'd2,
        PM_OFF  = 2'd3
    } pm_mode_e;

    // Override phase after power-up versus normal qualified operation.
    typedef enum logic {
        PH_OVERRIDE = 1'b0,
        PH_NORMAL   = 1'b1
    } pm_phase_e;

    // Target state selected by the pair of sync activity flags.
    function automatic pm_mode_e sync_to_mode(input logic h_live, input logic v_live);
        pm_mode_e m;
        case ({h_live, v_live})
            2'b11:   m = PM_ON;
            2'b01:   m = PM_STBY;
            2'b10:   m = PM_SUSP;
            default: m = PM_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dps_tick_gen.sv
// Prescaler: emits a one-clock tick every DIV clocks, first tick DIV-1
// clocks after reset release. Assumes DIV >= 1 (DIV = 1 ticks every clock).
module dps_tick_gen #(
    parameter int unsigned DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    assign tick = (div_q == LAST);

    // Free-running divider that wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    p_div_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);

endmodule

// File: rtl/dps_dwell_timer.sv
// Dwell qualifier: counts ticks while `run` is held; `fire` pulses on the
// LIMIT-th tick. Dropping `run` clears the count at once.
// Assumes LIMIT >= 1 and that `tick` is a single-clock pulse.
module dps_dwell_timer #(
    parameter int unsigned LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic fire
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign fire = run & tick & (cnt_q == LAST);

    // Tick counter, cleared when qualification stops or completes.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run || fire)   cnt_q <= '0;
        else if (tick)           cnt_q <= cnt_q + 1'b1;
    end

    p_count_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R6 / R10: an interrupted qualification starts over from zero.
    p_idle_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/dps_mode_fsm.sv
// Power state decision: holds the displayed state and the override phase,
// runs the entry and recovery qualifiers and applies immediate moves
// between saving states. Assumes h_active/v_active are synchronous.
module dps_mode_fsm
    import dps_pkg::*;
#(
    parameter int unsigned ENTRY_TICKS = 189,
    parameter int unsigned RECOV_TICKS = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     h_active,
    input  logic     v_active,
    input  logic     tick,
    output pm_mode_e mode_o
);
    pm_mode_e  cond;
    pm_mode_e  mode_q, mode_d;
    pm_phase_e phase_q, phase_d;
    logic      entry_run, entry_fire;
    logic      recov_run, recov_fire;

    assign cond = sync_to_mode(h_active, v_active);

    // Qualification windows: leaving ON and coming back to ON.
    assign entry_run = (phase_q == PH_NORMAL) && (mode_q == PM_ON) && (cond != PM_ON);
    assign recov_run = (phase_q == PH_NORMAL) && (mode_q != PM_ON) && (cond == PM_ON);

    dps_dwell_timer #(.LIMIT(ENTRY_TICKS)) entry_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (entry_run),
        .tick  (tick),
        .fire  (entry_fire)
    );

    dps_dwell_timer #(.LIMIT(RECOV_TICKS)) recov_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (recov_run),
        .tick  (tick),
        .fire  (recov_fire)
    );

    // Next-state decision for phase and displayed state.
    always_comb begin
        mode_d  = mode_q;
        phase_d = phase_q;
        if (phase_q == PH_OVERRIDE) begin
            if (cond != PM_OFF) phase_d = PH_NORMAL;
        end else if (mode_q == PM_ON) begin
            if (entry_fire) mode_d = cond;
        end else if (cond == PM_ON) begin
            if (recov_fire) mode_d = PM_ON;
        end else if (cond != mode_q) begin
            mode_d = cond;
        end
    end

    // State registers; reset enters the override evaluation showing ON.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OVERRIDE;
            mode_q  <= PM_ON;
        end else begin
            phase_q <= phase_d;
            mode_q  <= mode_d;
        end
    end

    assign mode_o = mode_q;

    p_override_holds_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_OVERRIDE |-> mode_q == PM_ON);

    p_override_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_NORMAL |=> phase_q == PH_NORMAL);

    p_leave_on_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == PM_ON && mode_q != PM_ON) |-> $past(entry_fire));

    p_return_on_checked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) != PM_ON && mode_q == PM_ON) |-> $past(recov_fire));

    p_hop_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_NORMAL && mode_q != PM_ON && cond != PM_ON && cond != mode_q)
        |=> mode_q == $past(cond));

endmodule

// File: rtl/dps_out_stage.sv
// Output register stage: decodes the displayed state into active-low
// indicators from flops, so no decode glitch reaches the pins.
// The combined saving indicator is built only when COMBINED_EN is set.
module dps_out_stage
    import dps_pkg::*;
#(
    parameter bit COMBINED_EN = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pm_mode_e mode_i,
    output logic     stby_n,
    output logic     susp_n,
    output logic     off_n,
    output logic     save_any_n
);
    // Individual indicators, all inactive after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stby_n <= 1'b1;
            susp_n <= 1'b1;
            off_n  <= 1'b1;
        end else begin
            stby_n <= (mode_i != PM_STBY);
            susp_n <= (mode_i != PM_SUSP);
            off_n  <= (mode_i != PM_OFF);
        end
    end

    generate
        if (COMBINED_EN) begin : g_combined
            // Combined indicator for either of the two lighter saving states.
            always_ff @(posedge clk) begin
                if (!rst_n) save_any_n <= 1'b1;
                else        save_any_n <= !((mode_i == PM_STBY) || (mode_i == PM_SUSP));
            end

            p_combined_matches_r11: assert property (@(posedge clk) disable iff (!rst_n)
                save_any_n == (stby_n & susp_n));
        end else begin : g_no_combined
            assign save_any_n = 1'b1;
        end
    endgenerate

    p_one_indicator_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~stby_n, ~susp_n, ~off_n}));

endmodule

// File: rtl/dps_power_ctrl.sv
// Top of the display power state controller: prescaler, state decision and
// registered active-low outputs. Assumes the activity flags are synchronous
// to clk; reset is synchronous, active low, and marks manual power-up.
module dps_power_ctrl #(
    parameter int unsigned TICK_DIV    = 1024,
    parameter int unsigned ENTRY_TICKS = 189,
    parameter int unsigned RECOV_TICKS = 12,
    parameter bit          COMBINED_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_active,
    input  logic v_active,
    output logic stby_n,
    output logic susp_n,
    output logic off_n,
    output logic save_any_n
);
    logic              tick;
    dps_pkg::pm_mode_e mode;

    dps_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dps_mode_fsm #(
        .ENTRY_TICKS (ENTRY_TICKS),
        .RECOV_TICKS (RECOV_TICKS)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_active (h_active),
        .v_active (v_active),
        .tick     (tick),
        .mode_o   (mode)
    );

    dps_out_stage #(.COMBINED_EN(COMBINED_EN)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .stby_n     (stby_n),
        .susp_n     (susp_n),
        .off_n      (off_n),
        .save_any_n (save_any_n)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (stby_n && susp_n && off_n && save_any_n));

endmodule

// File: tb/dps_power_ctrl_tb_top.sv
// Bench: sweeps entry, hop and recovery over all saving states with small
// tick counts; expected timing windows come from the requirement formulas.
module dps_power_ctrl_tb_top;
    localparam int D = 4;   // clocks per tick
    localparam int E = 5;   // entry ticks
    localparam int R = 3;   // recovery ticks
    localparam int E_LO = (E - 1) * D + 1;
    localparam int E_HI = E * D + 1;
    localparam int R_LO = (R - 1) * D + 1;
    localparam int R_HI = R * D + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_active = 1'b0;
    logic v_active = 1'b0;
    logic stby_n, susp_n, off_n, save_any_n;
    int   n_checks = 0;
    int   n_fails  = 0;

    always #5 clk = ~clk;

    dps_power_ctrl #(
        .TICK_DIV    (D),
        .ENTRY_TICKS (E),
        .RECOV_TICKS (R),
        .COMBINED_EN (1'b1)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_active   (h_active),
        .v_active   (v_active),
        .stby_n     (stby_n),
        .susp_n     (susp_n),
        .off_n      (off_n),
        .save_any_n (save_any_n)
    );

    // Mode numbers: 0 ON, 1 STAND-BY, 2 SUSPEND, 3 OFF.
    task automatic apply(input int m);
        h_active = (m == 0) || (m == 2);
        v_active = (m == 0) || (m == 1);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_mode(input int m, input string tag);
        logic [3:0] act, exp;
        act = {stby_n, susp_n, off_n, save_any_n};
        exp = {m != 1, m != 2, m != 3, !(m == 1 || m == 2)};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: outputs %b expected %b (mode %0d)", tag, act, exp, m);
        end
    endtask

    // Apply saving mode m from ON and check the entry window (R5, R4).
    task automatic enter_from_on(input int m, input string tag);
        apply(m);
        wait_n(E_LO);
        check_mode(0, {tag, " R5 early"});
        wait_n(E_HI - E_LO);
        check_mode(m, {tag, " R5 late / R4"});
    endtask

    // From saving state m, return to ON and check the recovery window (R8).
    task automatic recover(input int m, input string tag);
        apply(0);
        wait_n(R_LO);
        check_mode(m, {tag, " R8 early"});
        wait_n(R_HI - R_LO);
        check_mode(0, {tag, " R8 late"});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        // R1: reset state
        apply(3);
        wait_n(5);
        check_mode(0, "R1 during reset");
        rst_n = 1'b1;
        wait_n(1);
        check_mode(0, "R1 after reset");

        // R2: override holds ON with both syncs silent
        wait_n(3 * E * D);
        check_mode(0, "R2 override hold");

        // R3: pulses end override; silence is then qualified to OFF
        apply(0);
        wait_n(3);
        check_mode(0, "R3 override exit");
        enter_from_on(3, "R3");

        // Sweep: every saving state entered, every hop, every recovery
        recover(3, "sweep OFF");
        for (int s = 1; s <= 3; s++) begin
            enter_from_on(s, "sweep");
            for (int t = 1; t <= 3; t++) begin
                if (t != s) begin
                    apply(t);
                    wait_n(1);
                    check_mode(s, "R9 hop not early");
                    wait_n(1);
                    check_mode(t, "R9 hop / R11");
                    apply(s);
                    wait_n(2);
                    check_mode(s, "R9 hop back");
                end
            end
            recover(s, "sweep");
        end

        // R6: return to ON during qualification restarts it
        apply(1);
        wait_n(E_LO);
        apply(0);
        wait_n(2);
        check_mode(0, "R6 abort stays ON");
        enter_from_on(1, "R6 restart");
        recover(1, "R6");

        // R7: saving retarget during qualification does not restart it
        apply(1);
        wait_n(2 * D);
        apply(2);
        wait_n(E_LO - 2 * D);
        check_mode(0, "R7 early");
        wait_n(E_HI - E_LO);
        check_mode(2, "R7 final target");

        // R10: saving condition during recovery abandons it
        apply(0);
        wait_n(R_LO);
        check_mode(2, "R10 recovery pending");
        apply(3);
        wait_n(2);
        check_mode(3, "R10 retarget immediate");
        recover(3, "R10 full restart");

        // R3: reset with one sync active skips the override
        rst_n = 1'b0;
        apply(1);
        wait_n(4);
        rst_n = 1'b1;
        wait_n(E_LO);
        check_mode(0, "R3 no-override early");
        wait_n(E_HI + 1 - E_LO);
        check_mode(1, "R3 no-override qualified");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule